// File: doc/BRIEF.md
# Signed Adder-Subtractor with Overflow

This block is a purely combinational two's-complement adder-subtractor whose word width is set by a parameter (five bits by default). Two control lines pick the operation. With `add_en` high, the B operand goes through unchanged and the carry into bit 0 is zero, so the block forms A plus B. With `sub_en` high, every bit of B is inverted and the carry into bit 0 is forced to one, so the block forms A minus B. If both lines are low, the B path is all zeros and the result equals A.

The sum comes from a ripple chain of full adders. The carry out of the sign position appears on its own port and is not part of the result. A signed overflow flag is set when the two effective addends (A, and B or its inverse) share a sign and the result sign differs from it. Because subtraction uses the inverted B, the corner case of the most negative value minus one is flagged correctly.

Top module: `signed_addsub`

## Requirements
- R1: With add_en=1 and sub_en=0, result equals (A + B) modulo 2^WIDTH.
- R2: With sub_en=1 and add_en=0, result equals (A - B) modulo 2^WIDTH.
- R3: With add_en=0 and sub_en=0, result equals A, and carry_out and overflow are both 0.
- R4: With add_en=1 and sub_en=1 (an illegal request), every output matches the sub_en-only case for the same operands.
- R5: carry_out is bit WIDTH of the unsigned sum A + B' + c0. Here B' is B in add mode and the bitwise inverse of B in subtract mode, and c0 is 1 only in subtract mode. In subtract mode this makes carry_out 1 exactly when A >= B taken as unsigned values.
- R6: In add mode, overflow is 1 exactly when the signed sum of A and B (MSB is the sign bit, 1 means negative) lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R7: In subtract mode, overflow is 1 exactly when the signed difference A - B lies outside that same range. At WIDTH=5, A=10000 (-16) minus B=00001 gives result 01111 with overflow 1.
- R8: The carry out is excluded from the result. At WIDTH=5, 01001 (+9) plus 10111 (-9) gives result 00000, carry_out 1 and overflow 0.
- R9: overflow is never 1 when A and the effective B' differ in their sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Minuend or augend, two's complement |
| op_b | input | WIDTH | Subtrahend or addend, two's complement |
| add_en | input | 1 | Selects addition: B passes unchanged |
| sub_en | input | 1 | Selects subtraction: B inverted, carry-in 1 |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Raw carry out of the sign position |
| overflow | output | 1 | Signed overflow flag |

## Verification
The embedded assertions are re-evaluated whenever the inputs change. They check that the chain's carry and sum match the arithmetic sum of its effective operands, that the B gating gives zeros when idle and the inverse in subtract mode, that the flag stays clear for operands of unlike sign, and that a raised flag always comes with a result sign that differs from A. Only the bench scenarios can show that the flag rises exactly when the true signed value leaves the range, that the both-high request behaves like subtraction, and that the named corner values such as +9 plus -9 and -16 minus 1 produce the right words. For that the bench runs every operand pair under all four control combinations and adds seeded random and directed cases.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_ADD  = 2'd1,
        MODE_SUB  = 2'd2
    } addsub_mode_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // Subtract wins when both requests are raised.
    function automatic addsub_mode_e decode_mode(input logic add_req, input logic sub_req);
        if (sub_req)      return MODE_SUB;
        else if (add_req) return MODE_ADD;
        else              return MODE_PASS;
    endfunction

    function automatic fa_out_t fa_eval(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

endpackage

// File: rtl/addsub_operand_gate.sv
module addsub_operand_gate
    import addsub_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             add_req,
    input  logic             sub_req,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_seed
);
    addsub_mode_e mode;
    logic         pass_true;
    logic         pass_inv;

    always_comb begin
        mode      = decode_mode(add_req, sub_req);
        pass_true = (mode == MODE_ADD);
        pass_inv  = (mode == MODE_SUB);
    end

    // Each bit: true-B gate ORed with inverted-B gate.
    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        assign b_eff[i] = (b_in[i] & pass_true) | (~b_in[i] & pass_inv);
    end

    assign carry_seed = pass_inv;

    always_comb begin
        if (!add_req && !sub_req) begin
            AST_IDLE_ZERO_B: assert (b_eff == '0 && !carry_seed) else $error("idle B path not zero"); // R3
        end
        if (sub_req) begin
            AST_SUB_INVERTS: assert (b_eff == ~b_in && carry_seed) else $error("subtract path not inverted"); // R2
        end
    end

endmodule

// File: rtl/addsub_full_adder.sv
module addsub_full_adder
    import addsub_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    fa_out_t r;

    always_comb begin
        r  = fa_eval(x, y, ci);
        s  = r.sum;
        co = r.carry;
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int EXT = WIDTH + 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        addsub_full_adder u_fa (
            .x  (a[i]),
            .y  (b[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign cout = chain[WIDTH];

    always_comb begin
        AST_CHAIN_ARITH: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + EXT'(cin)))
            else $error("ripple chain disagrees with arithmetic sum"); // R5
    end

endmodule

// File: rtl/addsub_ovf_detect.sv
module addsub_ovf_detect (
    input  logic a_sign,
    input  logic b_sign,
    input  logic r_sign,
    output logic ovf
);
    // Like signs in, unlike sign out.
    assign ovf = (a_sign ~^ b_sign) & (r_sign ^ a_sign);

endmodule

// File: rtl/signed_addsub.sv
module signed_addsub #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             add_en,
    input  logic             sub_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c0;

    addsub_operand_gate #(.WIDTH(WIDTH)) u_gate (
        .b_in       (op_b),
        .add_req    (add_en),
        .sub_req    (sub_en),
        .b_eff      (b_eff),
        .carry_seed (c0)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_chain (
        .a    (op_a),
        .b    (b_eff),
        .cin  (c0),
        .sum  (result),
        .cout (carry_out)
    );

    addsub_ovf_detect u_ovf (
        .a_sign (op_a[MSB]),
        .b_sign (b_eff[MSB]),
        .r_sign (result[MSB]),
        .ovf    (overflow)
    );

    always_comb begin
        if (op_a[MSB] != b_eff[MSB]) begin
            AST_NO_OVERFLOW: assert (!overflow) else $error("overflow with unlike signs"); // R9
        end
        if (overflow) begin
            AST_OVF_SIGN_FLIP: assert (result[MSB] != op_a[MSB]) else $error("overflow without sign change"); // R6
        end
        if (!add_en && !sub_en) begin
            AST_IDLE_PASS: assert (result == op_a && !carry_out && !overflow) else $error("idle mode altered A"); // R3
        end
    end

endmodule

// File: tb/signed_addsub_bench.sv
module signed_addsub_bench;
    localparam int N    = 5;
    localparam int HALF = 1 << (N - 1);
    localparam int FULL = 1 << N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         add_en = 1'b0;
    logic         sub_en = 1'b0;
    logic [N-1:0] result;
    logic         carry_out;
    logic         overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    signed_addsub #(.WIDTH(N)) u_signed_addsub (
        .op_a      (op_a),
        .op_b      (op_b),
        .add_en    (add_en),
        .sub_en    (sub_en),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic int to_signed(input int u);
        return (u >= HALF) ? u - FULL : u;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Apply one vector and compare all outputs with expected values.
    task automatic run_vec(input int a, input int b, input bit ad, input bit sb);
        int    er, ec, eo, sv;
        string tr, to;
        @(posedge clk);
        op_a   = N'(a);
        op_b   = N'(b);
        add_en = ad;
        sub_en = sb;
        @(negedge clk);
        if (sb) begin
            sv = to_signed(a) - to_signed(b);
            er = (a - b + FULL) % FULL;
            ec = (a >= b) ? 1 : 0;
            eo = (sv < -HALF || sv > HALF - 1) ? 1 : 0;
            tr = ad ? "R4" : "R2";
            to = ad ? "R4" : "R7";
        end else if (ad) begin
            sv = to_signed(a) + to_signed(b);
            er = (a + b) % FULL;
            ec = ((a + b) >= FULL) ? 1 : 0;
            eo = (sv < -HALF || sv > HALF - 1) ? 1 : 0;
            tr = "R1";
            to = "R6";
        end else begin
            er = a; ec = 0; eo = 0;
            tr = "R3";
            to = "R3";
        end
        check(tr, "result", int'(result), er);
        check((ad || sb) ? "R5" : "R3", "carry_out", int'(carry_out), ec);
        check(to, "overflow", int'(overflow), eo);
        if (to_signed(a) < 0 != ((sb ? to_signed((FULL - 1 - b)) : (ad ? to_signed(b) : 0)) < 0)
            && (ad || sb))
            check("R9", "overflow (unlike signs)", int'(overflow), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset-state vector: all inputs zero.
        check("R3", "result at start", int'(result), 0);
        check("R3", "carry at start", int'(carry_out), 0);
        check("R3", "overflow at start", int'(overflow), 0);

        // Directed corner cases.
        run_vec(9, 23, 1, 0);               // R8: +9 + -9
        check("R8", "9+(-9) result", int'(result), 0);
        check("R8", "9+(-9) carry", int'(carry_out), 1);
        check("R8", "9+(-9) overflow", int'(overflow), 0);
        run_vec(16, 1, 0, 1);               // R7: -16 - 1
        check("R7", "-16-1 result", int'(result), 15);
        check("R7", "-16-1 overflow", int'(overflow), 1);
        run_vec(0, 16, 0, 1);               // R7: 0 - (-16)
        run_vec(31, 16, 0, 1);              // R7: -1 - (-16)
        run_vec(15, 1, 1, 0);               // R6: 15 + 1
        run_vec(16, 16, 1, 0);              // R6: -16 + -16
        run_vec(16, 1, 1, 1);               // R4: both raised

        // Exhaustive sweep across all control combinations.
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < FULL; a++)
                for (int b = 0; b < FULL; b++)
                    run_vec(a, b, m[0], m[1]);

        // Seeded random mix.
        for (int k = 0; k < 500; k++)
            run_vec(int'($urandom % FULL), int'($urandom % FULL), 1'($urandom), 1'($urandom));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule